// File: doc/BRIEF.md
# Streaming Overlap-Add Accumulator

This block joins overlapping blocks of complex samples into one continuous stream. It collects a block of K*FFT signed complex samples through a valid/ready input stream. It then makes one pass over a 2*K*FFT-entry accumulation memory. The pass moves the running sum down by FFT/2 entries and adds the new block into the upper half. After the pass, it sends the finished window out as K*FFT samples on a valid/last output.

The memories allow one read and one write per clock, so the update pass takes about one cycle per entry. During the pass and during the output run, the input is held off. The read address leads the write address by one cycle, which covers the one-cycle read latency of the memory. Each entry is written only after every read that depends on its old value has been issued.

Top module: `ola_buffer`

## Requirements
- R1: While `rst_n` is low (synchronous, active-low), `in_ready` and `out_valid` are low. After `rst_n` rises, a clearing pass writes zero to all 2*K*FFT accumulator entries, one per cycle. `in_ready` first goes high 2*K*FFT cycles after reset is released.
- R2: While `in_ready` is high, a sample is taken only in a cycle where `in_valid` is high. Idle cycles inside a block are allowed. `in_valid` has no effect while `in_ready` is low.
- R3: Once the K*FFT-th sample of a block is accepted, `in_ready` stays low for exactly 2*K*FFT + K*FFT + 2 cycles. That is 2*K*FFT+1 cycles of update pass and K*FFT+1 cycles of output.
- R4: In the update pass, the new entry i equals the old entry i+FFT/2, for i below K*FFT.
- R5: For K*FFT <= i < 2*K*FFT-FFT/2, the new entry i equals the old entry i+FFT/2 plus staged sample i-K*FFT.
- R6: The top FFT/2 entries take the staged sample only. No old value reaches them.
- R7: `out_valid` first rises 2*K*FFT+2 cycles after the last sample of a block is accepted. It then stays high for K*FFT consecutive cycles and carries the new entries FFT/2 through FFT/2+K*FFT-1 in order.
- R8: Every sum wraps in 16-bit two's complement, with no saturation.
- R9: An accepted `in_last` at any position in a block is held. `out_last` is then high with the final output sample of that block's window, and the held flag clears. Windows that follow have `out_last` low until another `in_last` arrives.
- R10: `out_last` is never high without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts input |
| in_last | input | 1 | Marks the end of the input stream |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Output sample valid |
| out_last | output | 1 | Final sample of the last window |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |

## Verification
The bench counts clock edges from the acceptance of the final sample of each block. It expects the first output 2*K*FFT+2 cycles later, and `in_ready` back after 2*K*FFT+K*FFT+2 cycles. After reset it expects `in_ready` after 2*K*FFT cycles. All samples are taken on the falling edge, half a cycle after the registered outputs change. Output values are compared in order against an arithmetic model of the shift-and-add. A cycle-accurate timestamp is not needed for the values, because R7 fixes the output run as contiguous. The run checks both the first-valid cycle and the ready-return cycle.

// File: rtl/ola_buffer.sv
module ola_buffer #(
  parameter int K   = 2,
  parameter int FFT = 8,
  parameter int W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_last,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  output logic                out_last,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im
);
  localparam int KF  = K * FFT;
  localparam int N   = 2 * KF;
  localparam int H   = FFT / 2;
  localparam int AAW = $clog2(N);
  localparam int SAW = $clog2(KF);
  localparam int CW  = $clog2(N + H + 1);
  localparam logic [CW-1:0]  N_C   = CW'(N);
  localparam logic [CW-1:0]  N1_C  = CW'(N - 1);
  localparam logic [CW-1:0]  KF_C  = CW'(KF);
  localparam logic [CW-1:0]  KF1_C = CW'(KF - 1);
  localparam logic [CW-1:0]  H_C   = CW'(H);
  localparam logic [SAW-1:0] WEND  = SAW'(KF - 1);

  typedef enum logic [1:0] {S_CLR, S_FILL, S_UPD, S_OUT} phase_t;
  phase_t state;

  logic signed [W-1:0] acc_re [N];
  logic signed [W-1:0] acc_im [N];
  logic signed [W-1:0] st_re  [KF];
  logic signed [W-1:0] st_im  [KF];

  logic [CW-1:0]  cnt;
  logic [SAW-1:0] wcnt;
  logic [AAW-1:0] p_idx;
  logic           p_valid, sh_zero, add_en, dv, dl, last_seen;
  logic signed [W-1:0] aq_re, aq_im, sq_re, sq_im;

  wire in_fire = in_valid && in_ready;
  wire [CW-1:0] rsum  = cnt + H_C;
  wire [CW-1:0] sdiff = cnt - KF_C;
  wire [AAW-1:0] ra = (rsum < N_C) ? rsum[AAW-1:0] : '0;
  wire [SAW-1:0] sa = (cnt >= KF_C) ? sdiff[SAW-1:0] : '0;

  wire signed [W-1:0] sum_re = (sh_zero ? '0 : aq_re) + (add_en ? sq_re : '0);
  wire signed [W-1:0] sum_im = (sh_zero ? '0 : aq_im) + (add_en ? sq_im : '0);
  wire                acc_we = (state == S_CLR) || p_valid;
  wire [AAW-1:0]      acc_wa = (state == S_CLR) ? cnt[AAW-1:0] : p_idx;

  assign in_ready  = (state == S_FILL);
  assign out_valid = dv;
  assign out_last  = dl;
  assign out_re    = aq_re;
  assign out_im    = aq_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_CLR; cnt <= '0; wcnt <= '0; p_idx <= '0;
      p_valid <= 1'b0; sh_zero <= 1'b0; add_en <= 1'b0;
      dv <= 1'b0; dl <= 1'b0; last_seen <= 1'b0;
    end else begin
      case (state)
        S_CLR: begin
          cnt <= cnt + 1'b1;
          if (cnt == N1_C) begin state <= S_FILL; cnt <= '0; end
        end
        S_FILL: begin
          dv <= 1'b0; dl <= 1'b0;
          if (in_fire) begin
            if (in_last) last_seen <= 1'b1;
            wcnt <= wcnt + 1'b1;
            if (wcnt == WEND) begin wcnt <= '0; state <= S_UPD; cnt <= '0; end
          end
        end
        S_UPD: begin
          p_valid <= (cnt < N_C);
          p_idx   <= cnt[AAW-1:0];
          sh_zero <= (rsum >= N_C);
          add_en  <= (cnt >= KF_C);
          cnt     <= cnt + 1'b1;
          if (cnt == N_C) begin state <= S_OUT; cnt <= '0; end
        end
        default: begin
          p_valid <= 1'b0;
          if (cnt < KF_C) begin
            dv  <= 1'b1;
            dl  <= (cnt == KF1_C) && last_seen;
            if (cnt == KF1_C) last_seen <= 1'b0;
            cnt <= cnt + 1'b1;
          end else begin
            dv <= 1'b0; dl <= 1'b0; state <= S_FILL; cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((state == S_UPD && cnt < N_C) || (state == S_OUT && cnt < KF_C)) begin
      aq_re <= acc_re[ra];
      aq_im <= acc_im[ra];
    end
    if (state == S_UPD && cnt < N_C) begin
      sq_re <= st_re[sa];
      sq_im <= st_im[sa];
    end
  end

  always_ff @(posedge clk) begin
    if (acc_we) begin
      acc_re[acc_wa] <= (state == S_CLR) ? '0 : sum_re;
      acc_im[acc_wa] <= (state == S_CLR) ? '0 : sum_im;
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && in_fire) begin
      st_re[wcnt] <= in_re;
      st_im[wcnt] <= in_im;
    end
  end

  // R10
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R9
  last_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
  // R7
  out_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (out_valid || in_ready));
  // R2
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);
endmodule

// File: tb/ola_buffer_tb.sv
module ola_buffer_tb;
  localparam int K = 1, FFT = 4;
  localparam int KF = K * FFT, N = 2 * KF, H = FFT / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_last;
  logic signed [15:0] out_re, out_im;

  ola_buffer #(.K(K), .FFT(FFT), .W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_last(out_last), .out_re(out_re), .out_im(out_im));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, wd = 0, rd = 0, wr = 0;
  bit done = 1'b0;
  logic signed [15:0] m_re [N], m_im [N];
  logic signed [15:0] e_re [64], e_im [64];
  logic e_last [64];
  string e_tag [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd < wr) begin
        chk(out_re == e_re[rd], e_tag[rd], out_re, e_re[rd]);
        chk(out_im == e_im[rd], e_tag[rd], out_im, e_im[rd]);
        chk(out_last == e_last[rd], "R9 last", out_last, e_last[rd]);
      end else chk(1'b0, "R7 extra output", rd, wr);
      rd++;
    end else if (rst_n && out_last) chk(1'b0, "R10 last without valid", 1, 0);
  end

  task automatic send_block(input int blk, input int gap_at, input int last_at,
                            input bit wrap, input bit junk);
    logic signed [15:0] b_re [KF], b_im [KF], n_re [N], n_im [N];
    int n, fv;
    bit lst = 1'b0;
    for (int i = 0; i < KF; i++) begin
      b_re[i] = wrap ? 16'(32512 + i * 64) : 16'(blk * 123 - i * 457 + 300);
      b_im[i] = wrap ? 16'(-32000 - i * 300) : 16'(i * 911 - blk * 55);
    end
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < KF; i++) begin
      if (i == gap_at) begin
        in_valid = 1'b0; in_re = 16'sd999; @(negedge clk);
      end
      in_valid = 1'b1; in_re = b_re[i]; in_im = b_im[i]; in_last = (i == last_at);
      if (i == last_at) lst = 1'b1;
      @(negedge clk);
    end
    in_valid = junk; in_last = junk; in_re = 16'sd12345; in_im = -16'sd4321;
    for (int e = 0; e < N; e++) begin
      n_re[e] = ((e + H < N) ? m_re[e + H] : 16'sd0) + ((e >= KF) ? b_re[e - KF] : 16'sd0);
      n_im[e] = ((e + H < N) ? m_im[e + H] : 16'sd0) + ((e >= KF) ? b_im[e - KF] : 16'sd0);
    end
    for (int e = 0; e < N; e++) begin m_re[e] = n_re[e]; m_im[e] = n_im[e]; end
    for (int j = 0; j < KF; j++) begin
      e_re[wr] = n_re[H + j]; e_im[wr] = n_im[H + j];
      e_last[wr] = lst && (j == KF - 1);
      e_tag[wr] = (H + j < KF) ? "R4 shift" : (wrap ? "R5/R6/R8 sum" : "R5/R6 sum");
      wr++;
    end
    n = 0; fv = -1;
    while (!in_ready) begin
      if (out_valid && fv < 0) fv = n;
      n++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(fv == N + 2, "R7 first valid latency", fv, N + 2);
    chk(n == N + KF + 2, "R3 busy cycles", n, N + KF + 2);
  endtask

  initial begin
    int n;
    for (int e = 0; e < N; e++) begin m_re[e] = '0; m_im[e] = '0; end
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk(n == N, "R1 clear pass length", n, N);
    send_block(1, -1, -1, 1'b0, 1'b0);
    send_block(2, 2, -1, 1'b0, 1'b1);   // R2 junk held during busy
    send_block(3, -1, -1, 1'b1, 1'b0);  // R8 wrap
    send_block(4, 1, 2, 1'b1, 1'b1);    // R9 last mid-block
    send_block(5, -1, -1, 1'b0, 1'b0);
    send_block(6, 3, 3, 1'b0, 1'b0);
    send_block(7, -1, -1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(rd == wr, "R7 output count", rd, wr);
    finish_up();
  end
endmodule